// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides which power mode a multi-regulator motor driver chip is in, and drives the controls that each mode implies. In normal operation every regulator, the bridge outputs and the internal clock are on and the external reset pin is released. The host can request a hibernate state, in which each regulator takes the on/off value carried in the command word. It can also request a low power state, in which every regulator and the bridge outputs and the clock are shut down. Every wake-up passes through a timed startup state that holds the reset pin low before normal operation resumes.

The chip can act in a slave role, and this changes how the wake pin is used. In the slave role the wake pin is a level enable for low power mode, and a separate general-purpose input wakes the chip from hibernate. In the other roles low power mode is entered by a command, and the filtered wake pin ends it. A low-power tick drives a filter counter on the wake pin. Two sticky status bits record an external hibernate wake and any low level on the wake pin. A host read strobe clears both bits.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `mode_o` is 3 (startup), `rst_pin_n` is 0 and both status bits are 0. The block reaches normal mode `STARTUP_CYC` cycles after reset is released.
- R2: In normal mode (`mode_o` = 0), `reg_en` is all ones, and `bridge_oe`, `clk_en` and `rst_pin_n` are 1.
- R3: A `hib_cmd_wr` pulse in normal mode gives `mode_o` = 1 on the next cycle. In that state `reg_en` equals the `hib_cmd_data` written, `rst_pin_n` and `bridge_oe` are 0, and `clk_en` is 1. When `hib_cmd_wr` and `lp_cmd_wr` arrive in the same cycle, hibernate is entered.
- R4: Hibernate ends, with a move to startup on the next cycle, when the wake source is low. The wake source is `wake_n` in the non-slave roles and `gpio_wake_n` in the slave role (`role_slave` = 1). In the slave role `wake_n` has no effect on hibernate. An exit caused by the wake source sets `stat_hib_wake`.
- R5: In hibernate, any bit of `uv_flags` moves the block to startup on the next cycle. Such an exit leaves `stat_hib_wake` unchanged unless the wake source is also low.
- R6: In low power mode (`mode_o` = 2), `reg_en` is all zeros, and `bridge_oe`, `clk_en` and `rst_pin_n` are 0.
- R7: In the non-slave roles, a `lp_cmd_wr` pulse in normal mode enters low power mode on the next cycle. In the slave role `lp_cmd_wr` is ignored.
- R8: The wake filter counts the cycles in which `lp_tick` is 1 while `wake_n` is low. A high sample of `wake_n` clears the count. The filter has expired once the count reaches `FILT_LEN`.
- R9: In the slave role, an expired filter in normal mode enters low power mode on the next cycle. `wake_n` high in low power mode moves the block to startup on the next cycle.
- R10: In the non-slave roles, an expired filter in low power mode moves the block to startup on the next cycle.
- R11: `por_evt` in low power mode moves the block to startup on the next cycle, in any role.
- R12: `stat_awake_evt` becomes 1 the cycle after any cycle in which `wake_n` is low, whatever the mode.
- R13: A `stat_rd_clr` pulse clears both status bits on the next cycle. When a set event and the clear arrive in the same cycle, the bit is set.
- R14: The startup state lasts `STARTUP_CYC` cycles, then the block returns to normal mode. During startup `reg_en` is all ones, `rst_pin_n` and `bridge_oe` are 0, and `clk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hib_cmd_wr | input | 1 | Hibernate command write strobe |
| hib_cmd_data | input | NREG | Regulator on/off pattern to use in hibernate |
| lp_cmd_wr | input | 1 | Low power command write strobe |
| wake_n | input | 1 | Wake pin, active low |
| gpio_wake_n | input | 1 | Alternate hibernate wake input for the slave role, active low |
| role_slave | input | 1 | 1 selects the slave role |
| uv_flags | input | 4 | Undervoltage flags: main, internal, pump, 3.3 V |
| por_evt | input | 1 | Power-on-reset event |
| lp_tick | input | 1 | Free-running low-power tick enable for the filter |
| stat_rd_clr | input | 1 | Host read-clear strobe for the status bits |
| reg_en | output | NREG | Per-regulator enables |
| bridge_oe | output | 1 | Bridge output enable, 0 means high impedance |
| clk_en | output | 1 | Internal clock enable |
| rst_pin_n | output | 1 | Reset pin output, active low |
| mode_o | output | 2 | Mode: 0 normal, 1 hibernate, 2 low power, 3 startup |
| stat_hib_wake | output | 1 | Sticky flag: hibernate ended by the wake source |
| stat_awake_evt | output | 1 | Sticky flag: the wake pin was seen low |

## Verification
Two collisions get dedicated tests. The first is the sticky set and the host clear landing in the same cycle. The bench drives `wake_n` low in the same cycle as `stat_rd_clr`, and `stat_awake_evt` must read 1 on the next cycle. The second is a hibernate command and a low power command in the same write cycle, and the mode must become 1. A behavioural reference model in the bench updates on every rising edge, and on every falling edge each output is compared against it. This catches a wrong winner in either collision on the cycle it occurs.

// File: rtl/pwr_mode_pkg.sv
// Package: pwr_mode_pkg
// Shared mode encoding and supply-count constant for the power mode controller.
package pwr_mode_pkg;
    // Mode codes; the values are visible on mode_o.
    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_HIB    = 2'd1,
        PM_LP     = 2'd2,
        PM_START  = 2'd3
    } pm_state_t;

    // Number of monitored supply rails with undervoltage flags.
    localparam int UV_SRC = 4;
endpackage

// File: rtl/pwr_wake_filter.sv
// Module: pwr_wake_filter
// Low-level filter for the wake pin. Counts tick-qualified cycles while the
// pin stays low and saturates at FILT_LEN. Any high sample clears the count.
// Assumes: pin_n has already been synchronized to clk; tick is a one-cycle enable.
module pwr_wake_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN);

    logic [CW-1:0] cnt_q;

    // Count while the pin stays low; clear on a high sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pin_n) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The filter has expired once the count reaches its limit.
    assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/pwr_sticky_bits.sv
// Module: pwr_sticky_bits
// A bank of sticky status flags. A set pulse wins over the shared clear strobe.
// Assumes: set and clear pulses are single-cycle and synchronous to clk.
module pwr_sticky_bits #(
    parameter int NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_i,
    input  logic             clr_i,
    output logic [NBITS-1:0] q_o
);
    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        logic q_q;
        // Hold each flag; a set in the same cycle as the clear takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_q <= 1'b0;
            end else if (set_i[g]) begin
                q_q <= 1'b1;
            end else if (clr_i) begin
                q_q <= 1'b0;
            end
        end
        assign q_o[g] = q_q;
    end
endmodule

// File: rtl/pwr_mode_fsm.sv
// Module: pwr_mode_fsm
// Mode sequencer: normal, hibernate, low power and timed startup. It also holds
// the regulator pattern from the hibernate command.
// Assumes: command strobes are single-cycle; filt_expired comes from the wake
// filter on wake_n; reset enters the startup state.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int STARTUP_CYC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hib_cmd_wr,
    input  logic [NREG-1:0] hib_cmd_data,
    input  logic            lp_cmd_wr,
    input  logic            role_slave,
    input  logic            wake_n,
    input  logic            gpio_wake_n,
    input  logic            uv_any,
    input  logic            por_evt,
    input  logic            filt_expired,
    output pm_state_t       state_o,
    output logic [NREG-1:0] hib_mask_o,
    output logic            hib_wake_set_o
);
    localparam int SW = $clog2(STARTUP_CYC + 1);
    localparam logic [SW-1:0] SC_LAST = SW'(STARTUP_CYC - 1);

    pm_state_t       state_q, state_d;
    logic [SW-1:0]   sc_q;
    logic [NREG-1:0] mask_q;
    logic            wake_src_low;
    logic            lp_enter;
    logic            lp_leave;

    // Select the hibernate wake source for the current role.
    assign wake_src_low = role_slave ? !gpio_wake_n : !wake_n;
    // Low power entry: pin level enable in the slave role, command otherwise.
    assign lp_enter = role_slave ? filt_expired : lp_cmd_wr;
    // Low power exit: pin released in the slave role, filtered low otherwise.
    assign lp_leave = por_evt || (role_slave ? wake_n : filt_expired);

    // Compute the next mode from the current mode and the events.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PM_NORMAL: begin
                if (hib_cmd_wr)    state_d = PM_HIB;
                else if (lp_enter) state_d = PM_LP;
            end
            PM_HIB:   if (uv_any || wake_src_low) state_d = PM_START;
            PM_LP:    if (lp_leave) state_d = PM_START;
            PM_START: if (sc_q == SC_LAST) state_d = PM_NORMAL;
            default:  state_d = PM_START;
        endcase
    end

    // Register the mode and the startup counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_START;
            sc_q    <= '0;
        end else begin
            state_q <= state_d;
            sc_q    <= (state_q == PM_START && state_d == PM_START) ? sc_q + 1'b1 : '0;
        end
    end

    // Capture the regulator pattern when a hibernate command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (state_q == PM_NORMAL && hib_cmd_wr) begin
            mask_q <= hib_cmd_data;
        end
    end

    assign state_o        = state_q;
    assign hib_mask_o     = mask_q;
    assign hib_wake_set_o = (state_q == PM_HIB) && wake_src_low;
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Power mode sequencing controller. It joins the wake filter, the mode
// sequencer and the sticky status flags, and decodes the mode into the
// regulator, bridge, clock and reset-pin controls.
// Assumes: all inputs are synchronous to clk; synchronous active-low reset.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int FILT_LEN    = 4,
    parameter int STARTUP_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hib_cmd_wr,
    input  logic [NREG-1:0]   hib_cmd_data,
    input  logic              lp_cmd_wr,
    input  logic              wake_n,
    input  logic              gpio_wake_n,
    input  logic              role_slave,
    input  logic [UV_SRC-1:0] uv_flags,
    input  logic              por_evt,
    input  logic              lp_tick,
    input  logic              stat_rd_clr,
    output logic [NREG-1:0]   reg_en,
    output logic              bridge_oe,
    output logic              clk_en,
    output logic              rst_pin_n,
    output logic [1:0]        mode_o,
    output logic              stat_hib_wake,
    output logic              stat_awake_evt
);
    pm_state_t       state;
    logic [NREG-1:0] hib_mask;
    logic            hib_wake_set;
    logic            filt_expired;
    logic [1:0]      stat_set;
    logic [1:0]      stat_q;

    pwr_wake_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (wake_n),
        .tick    (lp_tick),
        .expired (filt_expired)
    );

    pwr_mode_fsm #(.NREG(NREG), .STARTUP_CYC(STARTUP_CYC)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .hib_cmd_wr     (hib_cmd_wr),
        .hib_cmd_data   (hib_cmd_data),
        .lp_cmd_wr      (lp_cmd_wr),
        .role_slave     (role_slave),
        .wake_n         (wake_n),
        .gpio_wake_n    (gpio_wake_n),
        .uv_any         (|uv_flags),
        .por_evt        (por_evt),
        .filt_expired   (filt_expired),
        .state_o        (state),
        .hib_mask_o     (hib_mask),
        .hib_wake_set_o (hib_wake_set)
    );

    // Bit 0: hibernate ended by the wake source; bit 1: wake pin seen low.
    assign stat_set = {!wake_n, hib_wake_set};

    pwr_sticky_bits #(.NBITS(2)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (stat_set),
        .clr_i (stat_rd_clr),
        .q_o   (stat_q)
    );

    // Decode the mode into the regulator, bridge, clock and reset-pin controls.
    always_comb begin
        reg_en    = '1;
        bridge_oe = 1'b0;
        clk_en    = 1'b1;
        rst_pin_n = 1'b0;
        case (state)
            PM_NORMAL: begin
                bridge_oe = 1'b1;
                rst_pin_n = 1'b1;
            end
            PM_HIB:  reg_en = hib_mask;
            PM_LP: begin
                reg_en = '0;
                clk_en = 1'b0;
            end
            default: ;
        endcase
    end

    assign mode_o         = state;
    assign stat_hib_wake  = stat_q[0];
    assign stat_awake_evt = stat_q[1];
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Module: pwr_mode_ctrl_chk
// Property checker for pwr_mode_ctrl, attached through bind. It sees the top's
// ports only.
module pwr_mode_ctrl_chk #(
    parameter int NREG = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hib_cmd_wr,
    input logic [NREG-1:0] hib_cmd_data,
    input logic            lp_cmd_wr,
    input logic            wake_n,
    input logic            role_slave,
    input logic [3:0]      uv_flags,
    input logic            por_evt,
    input logic [NREG-1:0] reg_en,
    input logic            bridge_oe,
    input logic            clk_en,
    input logic            rst_pin_n,
    input logic [1:0]      mode_o,
    input logic            stat_awake_evt
);
    // R2: normal mode releases the reset pin and enables the bridges.
    p_normal_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (rst_pin_n && bridge_oe && clk_en && (reg_en == '1)));

    // R3: an accepted hibernate command loads its pattern into the regulator enables.
    p_hib_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && hib_cmd_wr) |=> (mode_o == 2'd1 && reg_en == $past(hib_cmd_data) && !rst_pin_n));

    // R5: undervoltage in hibernate leads to startup.
    p_uv_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && (uv_flags != 4'd0)) |=> (mode_o == 2'd3));

    // R6: low power mode shuts down every output control.
    p_lp_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (!rst_pin_n && !bridge_oe && !clk_en && (reg_en == '0)));

    // R7: in the slave role a low power command is ignored while the pin stays high.
    p_slave_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && role_slave && lp_cmd_wr && !hib_cmd_wr && wake_n && $past(wake_n))
        |=> (mode_o == 2'd0));

    // R11: a power-on-reset event ends low power mode.
    p_por_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && por_evt) |=> (mode_o == 2'd3));

    // R12, R13: a low wake pin sets the event flag even against a clear.
    p_awake_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_n |=> stat_awake_evt);

    // R14: startup keeps the bridges off and the reset pin low.
    p_start_out_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> (!rst_pin_n && !bridge_oe && (reg_en == '1)));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NREG(NREG)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hib_cmd_wr     (hib_cmd_wr),
    .hib_cmd_data   (hib_cmd_data),
    .lp_cmd_wr      (lp_cmd_wr),
    .wake_n         (wake_n),
    .role_slave     (role_slave),
    .uv_flags       (uv_flags),
    .por_evt        (por_evt),
    .reg_en         (reg_en),
    .bridge_oe      (bridge_oe),
    .clk_en         (clk_en),
    .rst_pin_n      (rst_pin_n),
    .mode_o         (mode_o),
    .stat_awake_evt (stat_awake_evt)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
// Bench for pwr_mode_ctrl. A behavioural reference model advances on every
// rising edge, and every output is compared on the falling edge.
module pwr_mode_ctrl_tb_top;
    localparam int NREG = 8;
    localparam int FILT = 4;
    localparam int SCYC = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hib_cmd_wr = 1'b0;
    logic [NREG-1:0] hib_cmd_data = '0;
    logic            lp_cmd_wr = 1'b0;
    logic            wake_n = 1'b1;
    logic            gpio_wake_n = 1'b1;
    logic            role_slave = 1'b0;
    logic [3:0]      uv_flags = 4'd0;
    logic            por_evt = 1'b0;
    logic            lp_tick = 1'b1;
    logic            stat_rd_clr = 1'b0;
    logic [NREG-1:0] reg_en;
    logic            bridge_oe, clk_en, rst_pin_n, stat_hib_wake, stat_awake_evt;
    logic [1:0]      mode_o;

    pwr_mode_ctrl #(.NREG(NREG), .FILT_LEN(FILT), .STARTUP_CYC(SCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .hib_cmd_wr(hib_cmd_wr), .hib_cmd_data(hib_cmd_data),
        .lp_cmd_wr(lp_cmd_wr), .wake_n(wake_n), .gpio_wake_n(gpio_wake_n),
        .role_slave(role_slave), .uv_flags(uv_flags), .por_evt(por_evt),
        .lp_tick(lp_tick), .stat_rd_clr(stat_rd_clr), .reg_en(reg_en),
        .bridge_oe(bridge_oe), .clk_en(clk_en), .rst_pin_n(rst_pin_n),
        .mode_o(mode_o), .stat_hib_wake(stat_hib_wake), .stat_awake_evt(stat_awake_evt)
    );

    always #10 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    armed = 0;
    string ph = "R1";

    // Reference model state; modes are 0 normal, 1 hibernate, 2 low power, 3 startup.
    int              m_st = 3;
    int              m_cnt = 0;
    int              m_sc = 0;
    logic [NREG-1:0] m_mask = '0;
    bit              m_hw = 0;
    bit              m_aw = 0;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        cycles++;
        armed = 1;
        if (!rst_n) begin
            m_st = 3; m_cnt = 0; m_sc = 0; m_mask = '0; m_hw = 0; m_aw = 0;
        end else begin
            automatic bit exp_f = (m_cnt >= FILT);
            automatic bit src = role_slave ? !gpio_wake_n : !wake_n;
            automatic int nst = m_st;
            automatic bit set_hw = (m_st == 1) && src;
            if (m_st == 0) begin
                if (hib_cmd_wr) begin nst = 1; m_mask = hib_cmd_data; end
                else if (role_slave ? exp_f : lp_cmd_wr) nst = 2;
            end else if (m_st == 1) begin
                if (uv_flags != 0 || src) nst = 3;
            end else if (m_st == 2) begin
                if (por_evt || (role_slave ? wake_n : exp_f)) nst = 3;
            end else begin
                if (m_sc == SCYC - 1) nst = 0;
            end
            m_sc = (m_st == 3 && nst == 3) ? m_sc + 1 : 0;
            m_st = nst;
            if (wake_n) m_cnt = 0;
            else if (lp_tick && m_cnt < FILT) m_cnt++;
            if (set_hw) m_hw = 1; else if (stat_rd_clr) m_hw = 0;
            if (!wake_n) m_aw = 1; else if (stat_rd_clr) m_aw = 0;
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (armed) begin
            automatic logic [NREG-1:0] e_reg = (m_st == 1) ? m_mask : (m_st == 2) ? '0 : '1;
            chk(ph, "mode", int'(mode_o), m_st);
            chk(ph, "reg_en", int'(reg_en), int'(e_reg));
            chk(ph, "bridge_oe", int'(bridge_oe), int'(m_st == 0));
            chk(ph, "clk_en", int'(clk_en), int'(m_st != 2));
            chk(ph, "rst_pin_n", int'(rst_pin_n), int'(m_st == 0));
            chk("R4/R13", "stat_hib_wake", int'(stat_hib_wake), int'(m_hw));
            chk("R12/R13", "stat_awake_evt", int'(stat_awake_evt), int'(m_aw));
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wake_low(int n);
        wake_n = 1'b0; step(n); wake_n = 1'b1;
    endtask

    task automatic hib(logic [NREG-1:0] pat);
        hib_cmd_data = pat; hib_cmd_wr = 1'b1; step(1); hib_cmd_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        wait (cycles > 20000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        finish_run();
    end

    initial begin
        step(3);
        ph = "R1"; rst_n = 1'b1; step(SCYC + 2);
        ph = "R2"; step(3);
        ph = "R3"; hib(8'hA5); step(3);
        ph = "R4"; wake_low(1); ph = "R14"; step(SCYC + 2);
        ph = "R13"; stat_rd_clr = 1'b1; step(1); stat_rd_clr = 1'b0; step(1);
        wake_n = 1'b0; stat_rd_clr = 1'b1; step(1); wake_n = 1'b1; stat_rd_clr = 1'b0; step(2);
        stat_rd_clr = 1'b1; step(1); stat_rd_clr = 1'b0; step(1);
        ph = "R5"; hib(8'h3C); step(2); uv_flags = 4'b0100; step(1); uv_flags = 4'd0; step(SCYC + 2);
        ph = "R4"; role_slave = 1'b1; hib(8'h0F); step(2); wake_low(2); step(2);
        gpio_wake_n = 1'b0; step(1); gpio_wake_n = 1'b1; step(SCYC + 2); role_slave = 1'b0;
        ph = "R7"; lp_cmd_wr = 1'b1; step(1); lp_cmd_wr = 1'b0; step(3);
        ph = "R6"; step(3);
        ph = "R8"; wake_low(2); step(2);
        wake_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            lp_tick = i[0]; step(1);
        end
        wake_n = 1'b1; lp_tick = 1'b1; step(SCYC + 2);
        ph = "R11"; lp_cmd_wr = 1'b1; step(1); lp_cmd_wr = 1'b0; step(2);
        por_evt = 1'b1; step(1); por_evt = 1'b0; step(SCYC + 2);
        ph = "R7"; role_slave = 1'b1; lp_cmd_wr = 1'b1; step(1); lp_cmd_wr = 1'b0; step(3);
        ph = "R9"; wake_low(8); step(SCYC + 2);
        role_slave = 1'b0;
        ph = "R3"; hib_cmd_data = 8'h81; hib_cmd_wr = 1'b1; lp_cmd_wr = 1'b1; step(1);
        hib_cmd_wr = 1'b0; lp_cmd_wr = 1'b0; step(2);
        uv_flags = 4'b0001; step(1); uv_flags = 4'd0; step(SCYC + 2);
        ph = "R10"; lp_cmd_wr = 1'b1; step(1); lp_cmd_wr = 1'b0; step(2);
        wake_low(6); step(SCYC + 2);
        ph = "R12"; stat_rd_clr = 1'b1; step(1); stat_rd_clr = 1'b0; step(2);
        finish_run();
    end
endmodule